// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps wall-clock time and date as a chain of packed BCD digits: seconds, minutes, hours, day of week, day of month, month and a two-digit year. A single-cycle `sec_tick` enable advances the seconds digit. Carries ripple through every digit in the same clock, so the whole date moves in one cycle. Hours run in either 24-hour or 12-hour form, and a PM flag is kept for the 12-hour form. February gets 29 days when the year, taken modulo 4, equals a remainder chosen by two stored selector bits. The phase of the four-year cycle can therefore be matched to any year numbering.

A surrounding bus interface presets any digit through a one-nibble write port, and reads the whole state on the flat `cal_q` output. For production test, holding `freeze` high stops the seconds advance. A rising edge on `test_in` then steps one addressed digit directly. The digits below it are left alone, and the digits above it receive the carry as usual.

Top module: `bcd_calendar`

## Requirements
- R1: After reset `cal_q` reads 52'h0001010800000: year 00, month 01, day 01, weekday 0, 24-hour mode, 00:00:00, leap selector 00.
- R2: Digit code k sits at `cal_q[4k+3:4k]`. Codes are 0 seconds units, 1 seconds tens, 2 minutes units, 3 minutes tens, 4 hour units, 5 hour tens, 6 weekday, 7 day units, 8 day tens, 9 month units, 10 month tens, 11 year units, 12 year tens. Seconds and minutes units count 0–9 and their tens count 0–5, each carrying upward on wrap.
- R3: In 24-hour mode the hour counts 00–23. The step after 23 gives 00 and advances the day.
- R4: In 12-hour mode the hour runs 12, 01, …, 11. Stepping from 11 to 12 toggles PM, and the day advances only on the step from PM 11 to AM 12.
- R5: The hour-tens nibble holds the tens in bits 1:0, PM in bit 2 and 24-hour mode in bit 3. Writing it with bit 3 set clears PM.
- R6: The weekday counts 0–6 and steps whenever the day steps, including a test step of the day.
- R7: The day runs from 1 to the month length, which is 31, or 30 for months 04, 06, 09 and 11. The month runs 01–12, and year 99 rolls to 00.
- R8: Bits 3:2 of the day-tens nibble select the leap phase. February has 29 days when year mod 4 equals 0 for 00, 3 for 01, 2 for 10 and 1 for 11, and 28 days otherwise.
- R9: While `freeze` is high, `sec_tick` changes no digit.
- R10: While `freeze` is high, a rising edge of `test_in` steps the digit named by `test_sel` and carries upward. The digits below it are unchanged. Codes 0, 1, 3, 4 (whole hour), 7 (whole day, with weekday), 9 (whole month), 11 (whole year) and 12 (year tens alone, no carry) are accepted, and other codes change nothing. A held level steps only once.
- R11: While `freeze` is low, `test_in` changes no digit.
- R12: `wr_en` loads `wr_data` into the digit coded by `wr_sel`. Bits with no storage read 0, and no counting happens in a write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle seconds advance enable |
| freeze | input | 1 | High stops the seconds advance and enables test stepping |
| test_in | input | 1 | Test step level; each rising edge acts once |
| test_sel | input | 4 | Digit code stepped by a test edge |
| wr_en | input | 1 | Digit load strobe |
| wr_sel | input | 4 | Digit code to load |
| wr_data | input | 4 | Nibble to load |
| cal_q | output | 52 | All thirteen digit nibbles, code k at bits 4k+3:4k |

## Verification
Every result lands on the single clock edge that samples its stimulus. A tick, a write or the first high sample of `test_in` changes `cal_q` at that edge, because the carry chain is combinational and there is no pipeline. The test edge is found against the level registered one edge earlier, so no extra cycle is added. The bench drives each stimulus on a falling edge, removes it on the next falling edge, and compares `cal_q` at that same falling edge, half a period after the update. A held test level is compared only after it drops, so a second step would be seen.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int NIB_W    = 4;
  localparam int N_DIGITS = 13;
  localparam int CAL_W    = NIB_W * N_DIGITS;

  // digit codes, used both by the load port and by test stepping
  localparam logic [3:0] DG_S1   = 4'd0;
  localparam logic [3:0] DG_S10  = 4'd1;
  localparam logic [3:0] DG_MI1  = 4'd2;
  localparam logic [3:0] DG_MI10 = 4'd3;
  localparam logic [3:0] DG_H1   = 4'd4;
  localparam logic [3:0] DG_H10  = 4'd5;
  localparam logic [3:0] DG_WK   = 4'd6;
  localparam logic [3:0] DG_D1   = 4'd7;
  localparam logic [3:0] DG_D10  = 4'd8;
  localparam logic [3:0] DG_MO1  = 4'd9;
  localparam logic [3:0] DG_MO10 = 4'd10;
  localparam logic [3:0] DG_Y1   = 4'd11;
  localparam logic [3:0] DG_Y10  = 4'd12;

  // one decimal step of a BCD nibble, 9 wraps to 0
  function automatic logic [3:0] nib_inc(input logic [3:0] d);
    return (d >= 4'd9) ? 4'd0 : d + 4'd1;
  endfunction
endpackage

// File: rtl/cal_digit.sv
module cal_digit #(
  parameter logic [3:0] MAXV = 4'd9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld,
  input  logic [3:0] ld_val,
  input  logic       inc,
  output logic [3:0] q,
  output logic       co
);
  logic [3:0] q_n;

  always_comb begin
    q_n = q;
    co  = 1'b0;
    if (ld) begin
      q_n = ld_val;
    end else if (inc) begin
      if (q >= MAXV) begin
        q_n = 4'd0;
        co  = 1'b1;
      end else begin
        q_n = q + 4'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= 4'd0;
    end else if (ld || inc) begin
      q <= q_n;
    end
  end

  // R2 / R6: a step at the top value wraps to zero
  a_r2_digit_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !ld && q >= MAXV) |=> (q == 4'd0));
  // R9: without a step or load the digit holds
  a_r9_digit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !ld) |=> $stable(q));
endmodule

// File: rtl/cal_hour.sv
module cal_hour (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld_lo,
  input  logic       ld_hi,
  input  logic [3:0] ld_val,
  input  logic       inc,
  output logic [3:0] q_lo,
  output logic [3:0] q_hi,
  output logic       co
);
  import cal_pkg::*;

  logic [1:0] tens, tens_n;
  logic [3:0] units, units_n;
  logic       pm, pm_n;
  logic       m24, m24_n;
  logic [7:0] cur;

  assign cur = {2'b00, tens, units};

  always_comb begin
    tens_n  = tens;
    units_n = units;
    pm_n    = pm;
    m24_n   = m24;
    co      = 1'b0;
    if (ld_hi) begin
      tens_n = ld_val[1:0];
      m24_n  = ld_val[3];
      pm_n   = ld_val[3] ? 1'b0 : ld_val[2];
    end else if (ld_lo) begin
      units_n = ld_val;
    end else if (inc) begin
      if (m24 && cur >= 8'h23) begin
        tens_n  = 2'd0;
        units_n = 4'd0;
        co      = 1'b1;
      end else if (!m24 && cur == 8'h11) begin
        tens_n  = 2'd1;
        units_n = 4'd2;
        pm_n    = ~pm;
        co      = pm;
      end else if (!m24 && cur >= 8'h12) begin
        tens_n  = 2'd0;
        units_n = 4'd1;
      end else begin
        units_n = nib_inc(units);
        if (units >= 4'd9) tens_n = tens + 2'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tens  <= 2'd0;
      units <= 4'd0;
      pm    <= 1'b0;
      m24   <= 1'b1;
    end else if (ld_lo || ld_hi || inc) begin
      tens  <= tens_n;
      units <= units_n;
      pm    <= pm_n;
      m24   <= m24_n;
    end
  end

  assign q_lo = units;
  assign q_hi = {m24, pm, tens};

  // R4: noon and midnight crossing flips the half-day flag
  a_r4_pm_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !ld_lo && !ld_hi && !m24 && cur == 8'h11) |=> (pm != $past(pm)));
  // R3: the last hour of a 24-hour day returns to zero
  a_r3_day_end: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !ld_lo && !ld_hi && m24 && cur >= 8'h23) |=> (tens == 2'd0 && units == 4'd0));
  // R5: selecting the 24-hour form drops the half-day flag
  a_r5_mode_clears_pm: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_hi && ld_val[3]) |=> (!pm && m24));
endmodule

// File: rtl/cal_pair.sv
module cal_pair #(
  parameter int         HI_BITS = 4,
  parameter logic [3:0] FIRST   = 4'd0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_lo,
  input  logic               ld_hi,
  input  logic [3:0]         lo_val,
  input  logic [HI_BITS-1:0] hi_val,
  input  logic               inc,
  input  logic               inc_hi,
  input  logic [7:0]         lim,
  output logic [3:0]         q_lo,
  output logic [HI_BITS-1:0] q_hi,
  output logic               co
);
  import cal_pkg::*;

  logic [3:0]         lo_n;
  logic [HI_BITS-1:0] hi_n;
  logic [7:0]         cur;

  assign cur = {4'(q_hi), q_lo};

  always_comb begin
    lo_n = q_lo;
    hi_n = q_hi;
    co   = 1'b0;
    if (ld_lo) begin
      lo_n = lo_val;
    end else if (ld_hi) begin
      hi_n = hi_val;
    end else if (inc) begin
      if (cur >= lim) begin
        lo_n = FIRST;
        hi_n = '0;
        co   = 1'b1;
      end else begin
        lo_n = nib_inc(q_lo);
        if (q_lo >= 4'd9) hi_n = q_hi + HI_BITS'(1);
      end
    end else if (inc_hi) begin
      hi_n = HI_BITS'(nib_inc(4'(q_hi)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_lo <= FIRST;
      q_hi <= '0;
    end else if (ld_lo || ld_hi || inc || inc_hi) begin
      q_lo <= lo_n;
      q_hi <= hi_n;
    end
  end

  // R7: stepping at or past the limit restarts at the first value
  a_r7_pair_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !ld_lo && !ld_hi && cur >= lim) |=> (cur == {4'd0, FIRST}));
  // R7: stepping below the limit always moves the value
  a_r7_pair_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !ld_lo && !ld_hi && cur < lim) |=> (cur != $past(cur)));
endmodule

// File: rtl/cal_mlen.sv
module cal_mlen (
  input  logic       mo_hi,
  input  logic [3:0] mo_lo,
  input  logic       yr_t0,
  input  logic [1:0] yr_u,
  input  logic [1:0] phase,
  output logic [7:0] lim
);
  logic [1:0] rem;
  logic       leap;

  always_comb begin
    // 10 = 2 mod 4, so year mod 4 = 2*tens + units mod 4
    rem  = {yr_t0 ^ yr_u[1], yr_u[0]};
    leap = ((rem + phase) == 2'd0);
    case ({3'b000, mo_hi, mo_lo})
      8'h02:                     lim = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: lim = 8'h30;
      default:                   lim = 8'h31;
    endcase
  end
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sec_tick,
  input  logic        freeze,
  input  logic        test_in,
  input  logic [3:0]  test_sel,
  input  logic        wr_en,
  input  logic [3:0]  wr_sel,
  input  logic [3:0]  wr_data,
  output logic [51:0] cal_q
);
  import cal_pkg::*;

  localparam logic [3:0] LOW_MAX [4] = '{4'd9, 4'd5, 4'd9, 4'd5};

  // reset: asserted at once, released two edges later
  logic [1:0] rst_s;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_s <= 2'b00;
    else        rst_s <= {rst_s[0], 1'b1};
  end
  assign rst_ni = rst_s[1];

  // test edge detection
  logic test_q;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) test_q <= 1'b0;
    else         test_q <= test_in;
  end

  logic tick_go, test_go;
  assign tick_go = sec_tick && !freeze && !wr_en;
  assign test_go = test_in && !test_q && freeze && !wr_en;

  logic t_s1, t_s10, t_mi10, t_h, t_d, t_mo, t_y1, t_y10;
  assign t_s1   = test_go && (test_sel == DG_S1);
  assign t_s10  = test_go && (test_sel == DG_S10);
  assign t_mi10 = test_go && (test_sel == DG_MI10);
  assign t_h    = test_go && (test_sel == DG_H1);
  assign t_d    = test_go && (test_sel == DG_D1);
  assign t_mo   = test_go && (test_sel == DG_MO1);
  assign t_y1   = test_go && (test_sel == DG_Y1);
  assign t_y10  = test_go && (test_sel == DG_Y10);

  logic [N_DIGITS-1:0] ld;
  always_comb begin
    for (int k = 0; k < N_DIGITS; k++) ld[k] = wr_en && (wr_sel == 4'(k));
  end

  // seconds and minutes: four single digits
  logic [3:0] lo_inc, lo_co, lo_ld, lo_thit;
  logic [3:0] lo_q [4];
  assign lo_ld   = {ld[DG_MI10], ld[DG_MI1], ld[DG_S10], ld[DG_S1]};
  assign lo_thit = {t_mi10, 1'b0, t_s10, t_s1};

  for (genvar g = 0; g < 4; g++) begin : g_low
    if (g == 0) begin : g_first
      assign lo_inc[g] = tick_go | lo_thit[g];
    end else begin : g_rest
      assign lo_inc[g] = lo_co[g-1] | lo_thit[g];
    end
    cal_digit #(.MAXV(LOW_MAX[g])) u_dig (
      .clk(clk), .rst_n(rst_ni), .ld(lo_ld[g]), .ld_val(wr_data),
      .inc(lo_inc[g]), .q(lo_q[g]), .co(lo_co[g])
    );
  end

  // hours
  logic [3:0] hr_lo, hr_hi;
  logic       hr_co, hr_inc;
  assign hr_inc = lo_co[3] | t_h;
  cal_hour u_hour (
    .clk(clk), .rst_n(rst_ni), .ld_lo(ld[DG_H1]), .ld_hi(ld[DG_H10]),
    .ld_val(wr_data), .inc(hr_inc), .q_lo(hr_lo), .q_hi(hr_hi), .co(hr_co)
  );

  // leap phase selector kept beside the day tens
  logic [1:0] phase, phase_n;
  always_comb begin
    phase_n = phase;
    if (ld[DG_D10]) phase_n = wr_data[3:2];
  end
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)         phase <= 2'b00;
    else if (ld[DG_D10]) phase <= phase_n;
  end

  // day, weekday, month, year
  logic       day_inc, day_co, mo_inc, mo_co, yr_inc, yr_co;
  logic [3:0] dy_lo, mo_lo, yr_lo, yr_hi, wk_q;
  logic [1:0] dy_hi;
  logic       mo_hi, wk_co;
  logic [7:0] mlim;

  assign day_inc = hr_co | t_d;
  assign mo_inc  = day_co | t_mo;
  assign yr_inc  = mo_co | t_y1;

  cal_mlen u_mlen (
    .mo_hi(mo_hi), .mo_lo(mo_lo), .yr_t0(yr_hi[0]), .yr_u(yr_lo[1:0]),
    .phase(phase), .lim(mlim)
  );

  cal_pair #(.HI_BITS(2), .FIRST(4'd1)) u_day (
    .clk(clk), .rst_n(rst_ni), .ld_lo(ld[DG_D1]), .ld_hi(ld[DG_D10]),
    .lo_val(wr_data), .hi_val(wr_data[1:0]), .inc(day_inc), .inc_hi(1'b0),
    .lim(mlim), .q_lo(dy_lo), .q_hi(dy_hi), .co(day_co)
  );

  cal_digit #(.MAXV(4'd6)) u_week (
    .clk(clk), .rst_n(rst_ni), .ld(ld[DG_WK]), .ld_val(wr_data),
    .inc(day_inc), .q(wk_q), .co(wk_co)
  );

  cal_pair #(.HI_BITS(1), .FIRST(4'd1)) u_month (
    .clk(clk), .rst_n(rst_ni), .ld_lo(ld[DG_MO1]), .ld_hi(ld[DG_MO10]),
    .lo_val(wr_data), .hi_val(wr_data[0]), .inc(mo_inc), .inc_hi(1'b0),
    .lim(8'h12), .q_lo(mo_lo), .q_hi(mo_hi), .co(mo_co)
  );

  cal_pair #(.HI_BITS(4), .FIRST(4'd0)) u_year (
    .clk(clk), .rst_n(rst_ni), .ld_lo(ld[DG_Y1]), .ld_hi(ld[DG_Y10]),
    .lo_val(wr_data), .hi_val(wr_data), .inc(yr_inc), .inc_hi(t_y10),
    .lim(8'h99), .q_lo(yr_lo), .q_hi(yr_hi), .co(yr_co)
  );

  assign cal_q = {yr_hi, yr_lo, 3'b000, mo_hi, mo_lo, phase, dy_hi, dy_lo,
                  wk_q, hr_hi, hr_lo, lo_q[3], lo_q[2], lo_q[1], lo_q[0]};

  // R9: frozen with no write and no test level, nothing moves
  a_r9_freeze_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    (freeze && !test_in && !wr_en) |=> $stable(cal_q));
  // R11: test level is ignored while running without a tick
  a_r11_test_needs_freeze: assert property (@(posedge clk) disable iff (!rst_ni)
    (!freeze && !sec_tick && !wr_en) |=> $stable(cal_q));
  // R12: a write to seconds units lands exactly
  a_r12_write_lands: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && wr_sel == DG_S1) |=> (cal_q[3:0] == $past(wr_data)));
  // R12: a write elsewhere leaves seconds units untouched
  a_r12_write_no_count: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && wr_sel != DG_S1) |=> (cal_q[3:0] == $past(cal_q[3:0])));
  // R6: the weekday moves with every day step
  a_r6_weekday_follows: assert property (@(posedge clk) disable iff (!rst_ni)
    (day_inc && !wr_en) |=> (cal_q[27:24] != $past(cal_q[27:24])));
  // R7: a century carry leaves year 00
  a_r7_year_wrap: assert property (@(posedge clk) disable iff (!rst_ni)
    (yr_co && !wr_en && !wk_co) |=> (cal_q[51:44] == 8'h00));
endmodule

// File: tb/bcd_calendar_test.sv
module bcd_calendar_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sec_tick, freeze, test_in, wr_en;
  logic [3:0]  test_sel, wr_sel, wr_data;
  logic [51:0] cal_q;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  bcd_calendar uut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .freeze(freeze),
    .test_in(test_in), .test_sel(test_sel), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .cal_q(cal_q)
  );

  // {req[3:0], act[4:0] (bit4 = tick, else test code), preset[51:0], expect[51:0]}
  localparam int NV = 26;
  localparam logic [112:0] VEC [NV] = '{
    {4'd7,  5'h10, 52'h9912316A35959, 52'h0001010800000}, // R7 R3 R6 year end
    {4'd2,  5'h10, 52'h2401153881234, 52'h2401153881235}, // R2 plain second
    {4'd2,  5'h10, 52'h2401153900959, 52'h2401153901000}, // R2 minute carry
    {4'd4,  5'h10, 52'h2401153115959, 52'h2401153520000}, // R4 AM 11 -> PM 12
    {4'd4,  5'h10, 52'h2401153515959, 52'h2401164120000}, // R4 R6 PM 11 -> AM 12, day on
    {4'd4,  5'h10, 52'h2401153125959, 52'h2401153010000}, // R4 12 -> 01
    {4'd3,  5'h10, 52'h2401153895959, 52'h2401153900000}, // R3 09 -> 10
    {4'd8,  5'h10, 52'h2302282A35959, 52'h2303013800000}, // R8 year 23 phase 00
    {4'd8,  5'h10, 52'h2402282A35959, 52'h2402293800000}, // R8 year 24 leap
    {4'd8,  5'h10, 52'h2402292A35959, 52'h2403013800000}, // R8 Feb 29 end
    {4'd8,  5'h10, 52'h2302682A35959, 52'h2302693800000}, // R8 phase 01 -> rem 3
    {4'd8,  5'h10, 52'h2202A82A35959, 52'h2202A93800000}, // R8 phase 10 -> rem 2
    {4'd8,  5'h10, 52'h2402A82A35959, 52'h2403813800000}, // R8 phase 10 year 24 not leap
    {4'd8,  5'h10, 52'h2102E82A35959, 52'h2102E93800000}, // R8 phase 11 -> rem 1
    {4'd7,  5'h10, 52'h2404305A35959, 52'h2405016800000}, // R7 30-day month
    {4'd7,  5'h10, 52'h2401305A35959, 52'h2401316800000}, // R7 31-day month
    {4'd10, 5'h00, 52'h2401153881239, 52'h2401153881240}, // R10 seconds units
    {4'd10, 5'h01, 52'h2401153881257, 52'h2401153881307}, // R10 seconds tens
    {4'd10, 5'h03, 52'h2401153885234, 52'h2401153890234}, // R10 minutes tens
    {4'd10, 5'h04, 52'h2401153A31234, 52'h2401164801234}, // R10 hour
    {4'd6,  5'h07, 52'h2401316881234, 52'h2402010881234}, // R6 R10 day with weekday
    {4'd10, 5'h09, 52'h2412153881234, 52'h2501153881234}, // R10 month
    {4'd10, 5'h0B, 52'h2901153881234, 52'h3001153881234}, // R10 year
    {4'd10, 5'h0C, 52'h9501153881234, 52'h0501153881234}, // R10 year tens alone
    {4'd10, 5'h02, 52'h2401153881234, 52'h2401153881234}, // R10 code 2 refused
    {4'd10, 5'h06, 52'h2401153881234, 52'h2401153881234}  // R10 code 6 refused
  };

  task automatic check(input int req, input logic [51:0] got, input logic [51:0] exp,
                       input string what);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic do_write(input logic [3:0] sel, input logic [3:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load_all(input logic [51:0] v);
    freeze = 1'b1;
    for (int k = 0; k < 13; k++) do_write(4'(k), v[4*k +: 4]);
  endtask

  task automatic do_tick();
    @(negedge clk);
    freeze = 1'b0; sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0; freeze = 1'b1;
  endtask

  task automatic do_test(input logic [3:0] code);
    @(negedge clk);
    test_sel = code; test_in = 1'b1;
    @(negedge clk);
    test_in = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R1..all watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [51:0] snap;
    rst_n = 1'b0; sec_tick = 1'b0; freeze = 1'b1; test_in = 1'b0;
    test_sel = 4'd0; wr_en = 1'b0; wr_sel = 4'd0; wr_data = 4'd0;
    repeat (4) @(negedge clk);
    check(1, cal_q, 52'h0001010800000, "value during reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(1, cal_q, 52'h0001010800000, "value after reset");

    for (int i = 0; i < NV; i++) begin
      load_all(VEC[i][103:52]);
      if (VEC[i][108]) do_tick();
      else             do_test(VEC[i][107:104]);
      check(int'(VEC[i][112:109]), cal_q, VEC[i][51:0], "vector");
    end

    // R9: tick while frozen
    load_all(52'h2401153881234);
    @(negedge clk);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
    check(9, cal_q, 52'h2401153881234, "tick while frozen");

    // R11: test edge while running
    @(negedge clk);
    freeze = 1'b0; test_sel = 4'd0; test_in = 1'b1;
    @(negedge clk);
    test_in = 1'b0;
    @(negedge clk);
    freeze = 1'b1;
    check(11, cal_q, 52'h2401153881234, "test edge while running");

    // R10: a held level steps once
    @(negedge clk);
    test_sel = 4'd0; test_in = 1'b1;
    repeat (3) @(negedge clk);
    test_in = 1'b0;
    check(10, cal_q, 52'h2401153881235, "held test level");

    // R12: write in the same cycle as a tick
    @(negedge clk);
    freeze = 1'b0; sec_tick = 1'b1; wr_en = 1'b1; wr_sel = 4'd1; wr_data = 4'd0;
    @(negedge clk);
    sec_tick = 1'b0; wr_en = 1'b0; freeze = 1'b1;
    check(12, cal_q, 52'h2401153881205, "write beats tick");

    // R12: unstored bits read zero
    do_write(4'd10, 4'hF);
    snap = cal_q;
    check(12, {48'd0, snap[43:40]}, 52'd1, "month tens unused bits");

    // R5: mode bit clears PM, and 12-hour form keeps it
    do_write(4'd5, 4'hF);
    snap = cal_q;
    check(5, {48'd0, snap[23:20]}, 52'hB, "24h write clears PM");
    do_write(4'd5, 4'h5);
    snap = cal_q;
    check(5, {48'd0, snap[23:20]}, 52'h5, "12h write keeps PM");

    summary();
    $finish;
  end
endmodule